// File: doc/BRIEF.md
# CRC-5 Frame Generator and Checker

This block produces the 5-bit check code carried in the last byte of a 24-bit serial command/response frame. On the transmit side it builds the code over the address and data bytes. On the receive side it recomputes the code over a response and compares it with the code the response carried. A one-cycle pulse on `start_i` hands over a 24-bit frame. After a fixed number of cycles the block pulses `done_o` and presents the code, the compare flag and a ready-to-send frame.

The payload is the upper 19 bits of the frame. Before division, the lowest 5 bits of the frame are replaced by the constant 5'b00111. The resulting 24-bit word is then divided over GF(2) by the 6-bit generator 6'b110101 (x^5 + x^4 + x^2 + 1). The code is the 5-bit remainder.

A parameter selects the implementation:
- A bit-serial engine (the default) uses one division stage and takes one payload bit per cycle.
- A single-cycle engine unrolls all 19 stages into combinational logic.

Top module: `crc5_frame_engine`

## Requirements
- R1: While `rst_n` is low and after its release, `crc_o`, `done_o`, `match_o` and `tx_frame_o` are all zero until the first result is produced.
- R2: `crc_o` equals the 5-bit remainder of dividing the word {frame[23:5], 5'b00111} by the generator 6'b110101. Division starts with frame bit 23 as the most significant bit.
- R3: Bits 4:0 of the supplied frame have no effect on `crc_o`.
- R4: In the default bit-serial variant, `done_o` is high for exactly one cycle. That cycle comes 19 cycles after the cycle in which an accepted `start_i` was high. In the single-cycle variant it comes 1 cycle after.
- R5: A `start_i` that arrives while a computation is in progress is ignored. It adds no `done_o` pulse and does not change the result in progress. A `start_i` in the cycle where `done_o` is high is accepted.
- R6: With `done_o`, `match_o` is 1 exactly when `crc_o` equals bits 4:0 of the accepted frame. These are the received code bits of the third byte.
- R7: With `done_o`, `tx_frame_o` is {frame[23:8], 3'b000, crc_o}. The upper three bits of the third byte are always zero.
- R8: Between `done_o` pulses, `crc_o`, `match_o` and `tx_frame_o` keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to process `frame_i` |
| frame_i | input | 24 | Frame to encode or check; bits 4:0 carry the received code |
| crc_o | output | 5 | Computed code of the last frame |
| done_o | output | 1 | One-cycle pulse when a new result is presented |
| match_o | output | 1 | Computed code equals bits 4:0 of the frame |
| tx_frame_o | output | 24 | Frame with its third byte rebuilt as 3'b000 and the code |

## Verification
The checker keeps its own model of whether a request is pending and how many cycles have passed since it was accepted. This model assumes that `start_i` and `frame_i` hold known values whenever reset is released. It also assumes that the frame matters only in the cycle where a start is accepted. The stimulus follows these assumptions. It changes `start_i` and `frame_i` only on falling edges and raises `start_i` for single-cycle pulses. Deliberate starts during a busy interval and starts in the same cycle as `done_o` exercise the acceptance rule from both sides.

// File: rtl/crc5_pkg.sv
package crc5_pkg;
    localparam int unsigned DEF_FRAME_W = 24;
    localparam int unsigned DEF_CRC_W   = 5;
    localparam int unsigned DEF_BYTE_W  = 8;
    localparam logic [5:0]  DEF_POLY    = 6'h35;
    localparam logic [4:0]  DEF_SEED    = 5'h07;
endpackage

// File: rtl/crc5_div_step.sv
module crc5_div_step #(
    parameter int unsigned CRC_W = crc5_pkg::DEF_CRC_W,
    parameter logic [CRC_W:0] POLY = crc5_pkg::DEF_POLY
) (
    input  logic [CRC_W-1:0] rem_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] rem_o
);
    logic [CRC_W:0] widened;

    always_comb begin
        widened = {rem_i, bit_i};
        if (widened[CRC_W]) begin
            rem_o = widened[CRC_W-1:0] ^ POLY[CRC_W-1:0];
        end else begin
            rem_o = widened[CRC_W-1:0];
        end
    end
endmodule

// File: rtl/crc5_serial_core.sv
module crc5_serial_core #(
    parameter int unsigned FRAME_W = crc5_pkg::DEF_FRAME_W,
    parameter int unsigned CRC_W   = crc5_pkg::DEF_CRC_W,
    parameter logic [CRC_W:0]   POLY = crc5_pkg::DEF_POLY,
    parameter logic [CRC_W-1:0] SEED = crc5_pkg::DEF_SEED
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               res_valid_o,
    output logic [CRC_W-1:0]   res_o,
    output logic [FRAME_W-1:0] res_frame_o
);
    localparam int unsigned NSTEP = FRAME_W - CRC_W;
    localparam int unsigned SH_W  = NSTEP - 1;
    localparam int unsigned CNT_W = $clog2(NSTEP + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NSTEP - 1);

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [CRC_W-1:0]   rem;
        logic [SH_W-1:0]    sh;
        logic [FRAME_W-1:0] frame;
    } ser_state_t;

    ser_state_t st_d, st_q;
    logic [CRC_W-1:0] step_rem_in;
    logic             step_bit_in;
    logic [CRC_W-1:0] step_rem_out;

    always_comb begin
        if (st_q.busy) begin
            step_rem_in = st_q.rem;
            step_bit_in = st_q.sh[SH_W-1];
        end else begin
            step_rem_in = frame_i[FRAME_W-1 -: CRC_W];
            step_bit_in = frame_i[FRAME_W-CRC_W-1];
        end
    end

    crc5_div_step #(.CRC_W(CRC_W), .POLY(POLY)) step_i (
        .rem_i (step_rem_in),
        .bit_i (step_bit_in),
        .rem_o (step_rem_out)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.cnt   = CNT_W'(1);
                st_d.rem   = step_rem_out;
                st_d.sh    = {frame_i[FRAME_W-CRC_W-2:CRC_W], SEED};
                st_d.frame = frame_i;
            end
        end else begin
            st_d.rem = step_rem_out;
            st_d.sh  = {st_q.sh[SH_W-2:0], 1'b0};
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == LAST_CNT) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid_o = st_q.busy && (st_q.cnt == LAST_CNT);
    assign res_o       = step_rem_out;
    assign res_frame_o = st_q.frame;
endmodule

// File: rtl/crc5_parallel_core.sv
module crc5_parallel_core #(
    parameter int unsigned FRAME_W = crc5_pkg::DEF_FRAME_W,
    parameter int unsigned CRC_W   = crc5_pkg::DEF_CRC_W,
    parameter logic [CRC_W:0]   POLY = crc5_pkg::DEF_POLY,
    parameter logic [CRC_W-1:0] SEED = crc5_pkg::DEF_SEED
) (
    input  logic [FRAME_W-1:0] frame_i,
    output logic [CRC_W-1:0]   res_o
);
    localparam int unsigned NSTEP = FRAME_W - CRC_W;

    logic [FRAME_W-1:0] word;
    logic [CRC_W-1:0]   chain [0:NSTEP];

    assign word     = {frame_i[FRAME_W-1:CRC_W], SEED};
    assign chain[0] = word[FRAME_W-1 -: CRC_W];

    for (genvar k = 0; k < NSTEP; k++) begin : g_stage
        crc5_div_step #(.CRC_W(CRC_W), .POLY(POLY)) step_i (
            .rem_i (chain[k]),
            .bit_i (word[FRAME_W-CRC_W-1-k]),
            .rem_o (chain[k+1])
        );
    end

    assign res_o = chain[NSTEP];
endmodule

// File: rtl/crc5_frame_engine.sv
module crc5_frame_engine #(
    parameter int unsigned FRAME_W = crc5_pkg::DEF_FRAME_W,
    parameter int unsigned CRC_W   = crc5_pkg::DEF_CRC_W,
    parameter int unsigned BYTE_W  = crc5_pkg::DEF_BYTE_W,
    parameter logic [CRC_W:0]   POLY = crc5_pkg::DEF_POLY,
    parameter logic [CRC_W-1:0] SEED = crc5_pkg::DEF_SEED,
    parameter bit SERIAL = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic [CRC_W-1:0]   crc_o,
    output logic               done_o,
    output logic               match_o,
    output logic [FRAME_W-1:0] tx_frame_o
);
    localparam int unsigned LATENCY = SERIAL ? (FRAME_W - CRC_W) : 1;
    localparam logic [FRAME_W-1:0] HI_MASK =
        {{(FRAME_W-BYTE_W){1'b1}}, {BYTE_W{1'b0}}};

    typedef struct packed {
        logic [CRC_W-1:0]   crc;
        logic               done;
        logic               match;
        logic [FRAME_W-1:0] tx;
    } out_state_t;

    out_state_t out_d, out_q;
    logic               res_valid;
    logic [CRC_W-1:0]   res;
    logic [FRAME_W-1:0] res_frame;

    if (SERIAL) begin : g_serial
        crc5_serial_core #(
            .FRAME_W(FRAME_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)
        ) core_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_i     (start_i),
            .frame_i     (frame_i),
            .res_valid_o (res_valid),
            .res_o       (res),
            .res_frame_o (res_frame)
        );
    end else begin : g_parallel
        crc5_parallel_core #(
            .FRAME_W(FRAME_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)
        ) core_i (
            .frame_i (frame_i),
            .res_o   (res)
        );
        assign res_valid = start_i;
        assign res_frame = frame_i;
    end

    always_comb begin
        out_d      = out_q;
        out_d.done = 1'b0;
        if (res_valid) begin
            out_d.done  = 1'b1;
            out_d.crc   = res;
            out_d.match = (res == res_frame[CRC_W-1:0]);
            out_d.tx    = (res_frame & HI_MASK) | {{(FRAME_W-CRC_W){1'b0}}, res};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign crc_o      = out_q.crc;
    assign done_o     = out_q.done;
    assign match_o    = out_q.match;
    assign tx_frame_o = out_q.tx;
endmodule

// File: rtl/crc5_frame_checker.sv
module crc5_frame_checker #(
    parameter int unsigned FRAME_W = 24,
    parameter int unsigned CRC_W   = 5,
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned LATENCY = 19
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [FRAME_W-1:0] frame_i,
    input logic [CRC_W-1:0]   crc_o,
    input logic               done_o,
    input logic               match_o,
    input logic [FRAME_W-1:0] tx_frame_o
);
    localparam int unsigned CNT_W = $clog2(LATENCY + 1);
    localparam logic [FRAME_W-1:0] HI_MASK =
        {{(FRAME_W-BYTE_W){1'b1}}, {BYTE_W{1'b0}}};

    logic               pend_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] frm_q;
    logic               due;

    assign due = pend_q && (cnt_q == CNT_W'(LATENCY));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            frm_q  <= '0;
        end else if (start_i && (!pend_q || due)) begin
            pend_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
            frm_q  <= frame_i;
        end else if (due) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assert_done_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> due);

    assert_done_due_R4: assert property (@(posedge clk) disable iff (!rst_n)
        due |-> done_o);

    assert_match_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (match_o == (crc_o == frm_q[CRC_W-1:0])));

    assert_tx_layout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (tx_frame_o == ((frm_q & HI_MASK) | {{(FRAME_W-CRC_W){1'b0}}, crc_o})));

    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(crc_o) && $stable(match_o) && $stable(tx_frame_o)));
endmodule

bind crc5_frame_engine crc5_frame_checker #(
    .FRAME_W(FRAME_W), .CRC_W(CRC_W), .BYTE_W(BYTE_W), .LATENCY(LATENCY)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .frame_i    (frame_i),
    .crc_o      (crc_o),
    .done_o     (done_o),
    .match_o    (match_o),
    .tx_frame_o (tx_frame_o)
);

// File: tb/crc5_frame_engine_tb_top.sv
module crc5_frame_engine_tb_top;
    localparam int LAT      = 19;
    localparam int WD_LIMIT = 150000;

    typedef struct {
        logic [4:0]  crc;
        logic        match;
        logic [23:0] tx;
        int          due;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] frame_i = '0;
    logic [4:0]  crc_o;
    logic        done_o;
    logic        match_o;
    logic [23:0] tx_frame_o;

    int   cyc = 0;
    int   nchk = 0;
    int   nfail = 0;
    bit   ended = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;

    crc5_frame_engine dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .frame_i    (frame_i),
        .crc_o      (crc_o),
        .done_o     (done_o),
        .match_o    (match_o),
        .tx_frame_o (tx_frame_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4:0] ref_crc(logic [23:0] f);
        logic [23:0] v;
        v = {f[23:5], 5'b00111};
        for (int b = 23; b >= 5; b--) begin
            if (v[b]) v = v ^ (24'h35 << (b - 5));
        end
        return v[4:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    function automatic exp_t make_exp(logic [23:0] f, int due);
        exp_t e;
        e.crc   = ref_crc(f);
        e.match = (e.crc == f[4:0]);
        e.tx    = {f[23:8], 3'b000, e.crc};
        e.due   = due;
        return e;
    endfunction

    // Monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R5 unexpected done", 32'(done_o), 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                last_exp = e;
                chk(crc_o == e.crc, "R2 crc value", 32'(crc_o), 32'(e.crc));
                chk(match_o == e.match, "R6 match flag", 32'(match_o), 32'(e.match));
                chk(tx_frame_o == e.tx, "R7 tx frame", 32'(tx_frame_o), 32'(e.tx));
                chk(cyc == e.due, "R4 done cycle", 32'(cyc), 32'(e.due));
            end
        end
    end

    always @(posedge clk) begin
        if (cyc >= WD_LIMIT) begin
            chk(1'b0, "R4 watchdog cycles", 32'(cyc), 32'(WD_LIMIT));
            finish_run();
        end
    end

    // Driver: optional extra start during the busy interval (R5)
    task automatic run(input logic [23:0] f, input bit extra, input logic [23:0] xf);
        @(negedge clk);
        sb_q.push_back(make_exp(f, cyc + LAT));
        start_i = 1'b1;
        frame_i = f;
        @(negedge clk);
        start_i = 1'b0;
        frame_i = ~f;
        if (extra) begin
            repeat (4) @(negedge clk);
            start_i = 1'b1;
            frame_i = xf;
            @(negedge clk);
            start_i = 1'b0;
        end
        repeat (LAT + 3) @(negedge clk);
        chk(crc_o == last_exp.crc, "R8 crc held", 32'(crc_o), 32'(last_exp.crc));
        chk(tx_frame_o == last_exp.tx, "R8 tx held", 32'(tx_frame_o), 32'(last_exp.tx));
    endtask

    // Second start lands in the cycle of the first done (accepted per R5)
    task automatic run_b2b(input logic [23:0] f1, input logic [23:0] f2);
        @(negedge clk);
        sb_q.push_back(make_exp(f1, cyc + LAT));
        start_i = 1'b1;
        frame_i = f1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        sb_q.push_back(make_exp(f2, cyc + LAT));
        start_i = 1'b1;
        frame_i = f2;
        @(negedge clk);
        start_i = 1'b0;
        repeat (LAT + 3) @(negedge clk);
    endtask

    initial begin
        logic [4:0]  saved;
        logic [23:0] r;
        logic [23:0] good;
        repeat (3) @(negedge clk);
        chk(crc_o == 5'd0, "R1 reset crc", 32'(crc_o), 32'd0);
        chk(done_o == 1'b0, "R1 reset done", 32'(done_o), 32'd0);
        chk(match_o == 1'b0, "R1 reset match", 32'(match_o), 32'd0);
        chk(tx_frame_o == 24'd0, "R1 reset tx", 32'(tx_frame_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 1'b0 && crc_o == 5'd0, "R1 after release", 32'({done_o, crc_o}), 32'd0);

        run(24'h000000, 1'b0, '0);
        run(24'hFFFFFF, 1'b0, '0);
        run(24'h800000, 1'b0, '0);
        run(24'h000020, 1'b0, '0);
        run(24'h0000E0, 1'b0, '0);   // R7 upper third-byte bits cleared
        run(24'h123456, 1'b0, '0);

        // R3: only bits 4:0 differ
        run(24'hABCDE0, 1'b0, '0);
        saved = crc_o;
        run(24'hABCDFF, 1'b0, '0);
        chk(crc_o == saved, "R3 low bits ignored", 32'(crc_o), 32'(saved));

        // R6: received frame with correct and corrupted code
        good = {19'h5A5A5, 5'd0};
        good[4:0] = ref_crc(good);
        run(good, 1'b0, '0);
        chk(match_o == 1'b1, "R6 good frame accepted", 32'(match_o), 32'd1);
        run(good ^ 24'h000001, 1'b0, '0);
        chk(match_o == 1'b0, "R6 corrupt frame rejected", 32'(match_o), 32'd0);

        // R5: start while busy is ignored
        run(24'h3C3C3C, 1'b1, 24'hC3C3C3);
        run(24'h0F0F0F, 1'b1, 24'hFFFFFF);

        run_b2b(24'h111111, 24'h222222);

        r = 24'h5A3C1F;
        for (int i = 0; i < 24; i++) begin
            r = {r[22:0], r[23] ^ r[22] ^ r[21] ^ r[16]};
            if (i % 3 == 0) begin
                good = {r[23:5], ref_crc(r)};
                run(good, 1'b0, '0);
            end else begin
                run(r, (i % 4 == 1), ~r);
            end
        end

        chk(sb_q.size() == 0, "R4 all results delivered", 32'(sb_q.size()), 32'd0);
        finish_run();
    end
endmodule